// File: doc/BRIEF.md
# CAN Bit Timing Synchronizer

This block divides a core clock into time quanta and turns them into the bit grid of a CAN-style serial bus. A programmable prescaler sets the quantum length. Each bit is one quantum of synchronization segment, then a first timing segment that covers propagation and the first phase buffer, then a second phase buffer. The end of the first segment is the sample point. The block emits a one-cycle sample strobe together with the sampled bit value. It also emits a one-cycle bit-start strobe on the quantum that closes the synchronization segment.

The receive line is observed once per quantum. A recessive-to-dominant transition seen while the bus is idle restarts the bit grid (hard synchronization). Later transitions of the same kind move the grid by at most the resynchronization jump width. A late transition stretches the first segment and an early one trims the second. The node's own dominant transmission suppresses this correction, and only one correction is taken per bit. An optional three-quantum majority vote filters glitches at the sample point. Frame decoding, stuffing and CRC belong to the surrounding controller.

Top module: `bts_bit_sync`

## Requirements
- R1: One quantum lasts `brp_i`+1 core clocks, and with no falling edges on the receive line one bit lasts (`brp_i`+1)*(`tseg1_i`+`tseg2_i`+3) clocks. Each field is programmed as its length minus one.
- R2: With no falling edges, the sample strobe comes (`brp_i`+1)*(`tseg1_i`+1) clocks after the bit-start strobe, which places the sample point at the end of the first segment.
- R3: `sample_o` and `bit_start_o` are single-cycle pulses and are never high in the same cycle.
- R4: When `bus_idle_i` is high and a quantum sees the line fall from 1 to 0, that quantum ends a synchronization segment: `bit_start_o` pulses after it, and the sample follows `tseg1_i`+1 quanta later.
- R5: A falling edge seen in quantum k (0-based) of the first segment has a lateness of k+1 quanta. The first segment grows by min(k+1, `sjw_i`+1) quanta.
- R6: A falling edge seen in quantum k of the second segment, whose length is L, is early by L-k quanta. If L-k ≤ `sjw_i`+1, that quantum ends a synchronization segment and `bit_start_o` pulses after it. Otherwise the second segment shrinks by `sjw_i`+1 quanta.
- R7: After one resynchronization in a bit, further falling edges in that bit cause no adjustment.
- R8: While `tx_dom_i` is high, falling edges cause no resynchronization.
- R9: A falling edge seen in the synchronization quantum causes no adjustment.
- R10: Rising edges on the receive line never move the bit grid.
- R11: With `triple_i` low, `bit_o` takes the line value at the sample quantum. With it high, `bit_o` takes the majority of the values at the sample quantum and the two quanta before it. `bit_o` changes only together with a sample strobe.
- R12: Under reset both strobes are 0 and `bit_o` is 1 (recessive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Receive line, 0 = dominant |
| brp_i | input | 5 | Prescaler minus one (1..32 clocks per quantum) |
| tseg1_i | input | 4 | First segment length minus one |
| tseg2_i | input | 3 | Second segment length minus one (2..8 quanta) |
| sjw_i | input | 2 | Jump width minus one (1..4 quanta) |
| triple_i | input | 1 | Enable three-quantum majority sampling |
| bus_idle_i | input | 1 | Bus idle: falling edges hard-synchronize |
| tx_dom_i | input | 1 | This node drives dominant: no resynchronization |
| bit_o | output | 1 | Bit value taken at the last sample point |
| sample_o | output | 1 | One-cycle pulse at the sample point |
| bit_start_o | output | 1 | One-cycle pulse ending the synchronization quantum |

## Verification
Edge handling and segment bookkeeping can land on the same quantum. An early edge in the last quantum of the second segment is both a resynchronization and a bit boundary, so the bit-start strobe must move forward onto that quantum. A late edge stretches the first segment in the same quantum that counts toward the sample point. The bench drives falling edges onto chosen quanta: the last quantum of the second segment, a quantum early enough to force clipping, and the synchronization quantum itself. It then checks on which clock each strobe appears. A second edge is placed in a bit that has already been corrected, and the bench checks that the boundary stays where the first correction put it.

// File: rtl/bts_pkg.sv
package bts_pkg;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_TS1  = 2'd1,
        SEG_TS2  = 2'd2
    } seg_e;

    // per-core-clock event record from the receive front end
    typedef struct packed {
        logic tick;   // quantum boundary
        logic fall;   // line fell 1->0 across this quantum
        logic vote;   // bit value offered at this quantum
    } tq_ev_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/bts_tq_gen.sv
module bts_tq_gen #(
    parameter int BRP_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BRP_W-1:0] brp_i,
    output logic             tick_o
);
    localparam logic [BRP_W-1:0] ONE = BRP_W'(1);

    logic [BRP_W-1:0] cnt_q;

    // ">=" keeps the counter safe when brp_i shrinks mid-quantum
    assign tick_o = (cnt_q >= brp_i);

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + ONE;
    end
endmodule

// File: rtl/bts_rx_front.sv
module bts_rx_front
    import bts_pkg::*;
#(
    parameter bit HAS_VOTE = 1'b1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick_i,
    input  logic   rx_i,
    input  logic   triple_i,
    output tq_ev_t ev_o
);
    // line value at the previous two quanta, [0] most recent
    logic [1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst)         hist_q <= 2'b11;
        else if (tick_i) hist_q <= {hist_q[0], rx_i};
    end

    assign ev_o.tick = tick_i;
    assign ev_o.fall = tick_i & hist_q[0] & ~rx_i;

    generate
        if (HAS_VOTE) begin : g_vote
            assign ev_o.vote = triple_i ? maj3(hist_q[1], hist_q[0], rx_i) : rx_i;
        end else begin : g_raw
            assign ev_o.vote = rx_i;
        end
    endgenerate
endmodule

// File: rtl/bts_seg_ctrl.sv
module bts_seg_ctrl
    import bts_pkg::*;
#(
    parameter int T1_W  = 4,
    parameter int T2_W  = 3,
    parameter int SJW_W = 2,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  tq_ev_t           ev_i,
    input  logic [T1_W-1:0]  tseg1_i,
    input  logic [T2_W-1:0]  tseg2_i,
    input  logic [SJW_W-1:0] sjw_i,
    input  logic             bus_idle_i,
    input  logic             tx_dom_i,
    output logic             bit_o,
    output logic             sample_o,
    output logic             start_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    seg_e             seg_q, seg_n;
    logic [CNT_W-1:0] q_q, q_n;        // quantum index inside the segment
    logic [CNT_W-1:0] ext_q, ext_n;    // first-segment stretch
    logic [CNT_W-1:0] lim_q, lim_n;    // second-segment length this bit
    logic             done_q, done_n;  // resync already taken this bit
    logic             samp, strt;

    logic [CNT_W-1:0] t1len, t2len, sjwl;
    logic [CNT_W-1:0] err, adj, ext_c, lim;
    logic             hard, resync;

    assign t1len  = CNT_W'(tseg1_i) + ONE;
    assign t2len  = CNT_W'(tseg2_i) + ONE;
    assign sjwl   = CNT_W'(sjw_i) + ONE;
    assign hard   = ev_i.fall & bus_idle_i;
    assign resync = ev_i.fall & ~bus_idle_i & ~tx_dom_i & ~done_q;

    always_comb begin
        seg_n  = seg_q;
        q_n    = q_q;
        ext_n  = ext_q;
        lim_n  = lim_q;
        done_n = done_q;
        samp   = 1'b0;
        strt   = 1'b0;
        err    = '0;
        adj    = '0;
        ext_c  = ext_q;
        lim    = lim_q;
        if (ev_i.tick) begin
            if (hard || seg_q == SEG_SYNC) begin
                // this quantum closes a synchronization segment
                strt   = 1'b1;
                seg_n  = SEG_TS1;
                q_n    = '0;
                ext_n  = '0;
                lim_n  = t2len;
                done_n = 1'b0;
            end else if (seg_q == SEG_TS1) begin
                if (resync) begin
                    err    = q_q + ONE;
                    adj    = (err > sjwl) ? sjwl : err;
                    ext_c  = adj;
                    done_n = 1'b1;
                end
                ext_n = ext_c;
                if (q_q >= t1len + ext_c - ONE) begin
                    samp  = 1'b1;
                    seg_n = SEG_TS2;
                    q_n   = '0;
                end else begin
                    q_n = q_q + ONE;
                end
            end else begin
                if (resync) begin
                    err = lim_q - q_q;
                    adj = (err > sjwl) ? sjwl : err;
                end
                if (resync && adj == err) begin
                    // full correction: edge quantum becomes the sync quantum
                    strt   = 1'b1;
                    seg_n  = SEG_TS1;
                    q_n    = '0;
                    ext_n  = '0;
                    lim_n  = t2len;
                    done_n = 1'b0;
                end else begin
                    if (resync) begin
                        lim    = lim_q - adj;
                        done_n = 1'b1;
                    end
                    lim_n = lim;
                    if (q_q >= lim - ONE) begin
                        seg_n = SEG_SYNC;
                        q_n   = '0;
                    end else begin
                        q_n = q_q + ONE;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q    <= SEG_SYNC;
            q_q      <= '0;
            ext_q    <= '0;
            lim_q    <= '0;
            done_q   <= 1'b0;
            sample_o <= 1'b0;
            start_o  <= 1'b0;
            bit_o    <= 1'b1;
        end else begin
            seg_q    <= seg_n;
            q_q      <= q_n;
            ext_q    <= ext_n;
            lim_q    <= lim_n;
            done_q   <= done_n;
            sample_o <= samp;
            start_o  <= strt;
            if (samp) bit_o <= ev_i.vote;
        end
    end
endmodule

// File: rtl/bts_bit_sync.sv
module bts_bit_sync
    import bts_pkg::*;
#(
    parameter int BRP_W    = 5,
    parameter int TSEG1_W  = 4,
    parameter int TSEG2_W  = 3,
    parameter int SJW_W    = 2,
    parameter bit HAS_VOTE = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_i,
    input  logic [BRP_W-1:0]   brp_i,
    input  logic [TSEG1_W-1:0] tseg1_i,
    input  logic [TSEG2_W-1:0] tseg2_i,
    input  logic [SJW_W-1:0]   sjw_i,
    input  logic               triple_i,
    input  logic               bus_idle_i,
    input  logic               tx_dom_i,
    output logic               bit_o,
    output logic               sample_o,
    output logic               bit_start_o
);
    localparam int W12   = (TSEG1_W > TSEG2_W) ? TSEG1_W : TSEG2_W;
    localparam int WMAX  = (W12 > SJW_W) ? W12 : SJW_W;
    localparam int CNT_W = WMAX + 2;

    logic   tick;
    tq_ev_t ev;

    bts_tq_gen #(.BRP_W(BRP_W)) u_tq (
        .clk    (clk),
        .rst    (rst),
        .brp_i  (brp_i),
        .tick_o (tick)
    );

    bts_rx_front #(.HAS_VOTE(HAS_VOTE)) u_front (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick),
        .rx_i     (rx_i),
        .triple_i (triple_i),
        .ev_o     (ev)
    );

    bts_seg_ctrl #(
        .T1_W  (TSEG1_W),
        .T2_W  (TSEG2_W),
        .SJW_W (SJW_W),
        .CNT_W (CNT_W)
    ) u_seg (
        .clk        (clk),
        .rst        (rst),
        .ev_i       (ev),
        .tseg1_i    (tseg1_i),
        .tseg2_i    (tseg2_i),
        .sjw_i      (sjw_i),
        .bus_idle_i (bus_idle_i),
        .tx_dom_i   (tx_dom_i),
        .bit_o      (bit_o),
        .sample_o   (sample_o),
        .start_o    (bit_start_o)
    );
endmodule

// File: rtl/bts_bit_sync_chk.sv
module bts_bit_sync_chk #(
    parameter int BRP_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_i,
    input logic [BRP_W-1:0] brp_i,
    input logic             bus_idle_i,
    input logic             bit_o,
    input logic             sample_o,
    input logic             bit_start_o
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(sample_o && bit_start_o)); // R3

    AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        sample_o |=> !sample_o); // R3

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        bit_start_o |=> !bit_start_o); // R3

    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sample_o |-> $stable(bit_o)); // R11

    AST_HARD_SYNC: assert property (@(posedge clk) disable iff (rst)
        (brp_i == '0 && $past(brp_i) == '0 && bus_idle_i && $past(rx_i) && !rx_i)
        |=> bit_start_o); // R4

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!sample_o && !bit_start_o && bit_o)); // R12
endmodule

bind bts_bit_sync bts_bit_sync_chk #(.BRP_W(BRP_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_i        (rx_i),
    .brp_i       (brp_i),
    .bus_idle_i  (bus_idle_i),
    .bit_o       (bit_o),
    .sample_o    (sample_o),
    .bit_start_o (bit_start_o)
);

// File: tb/bts_bit_sync_bench.sv
`timescale 1ns/100ps
module bts_bit_sync_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_i = 1'b1;
    logic [4:0] brp_i = '0;
    logic [3:0] tseg1_i = 4'd6;
    logic [2:0] tseg2_i = 3'd1;
    logic [1:0] sjw_i = '0;
    logic       triple_i = 1'b0;
    logic       bus_idle_i = 1'b0;
    logic       tx_dom_i = 1'b0;
    logic       bit_o, sample_o, bit_start_o;

    always #2.5 clk = ~clk;

    bts_bit_sync u_bts_bit_sync (
        .clk(clk), .rst(rst), .rx_i(rx_i), .brp_i(brp_i),
        .tseg1_i(tseg1_i), .tseg2_i(tseg2_i), .sjw_i(sjw_i),
        .triple_i(triple_i), .bus_idle_i(bus_idle_i), .tx_dom_i(tx_dom_i),
        .bit_o(bit_o), .sample_o(sample_o), .bit_start_o(bit_start_o)
    );

    typedef struct packed {
        logic [4:0] brp;
        logic [3:0] t1;
        logic [2:0] t2;
        logic [1:0] sjw;
        int         d1;   // bit start to sample, clocks
        int         per;  // bit period, clocks
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{5'd0, 4'd6,  3'd1, 2'd0, 7,  10},
        '{5'd3, 4'd6,  3'd1, 2'd0, 28, 40},
        '{5'd1, 4'd3,  3'd2, 2'd1, 8,  16},
        '{5'd4, 4'd15, 3'd7, 2'd3, 80, 125},
        '{5'd0, 4'd0,  3'd1, 2'd0, 1,  4}
    };

    int  n_chk = 0;
    int  n_err = 0;
    bit  ended = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1'b1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic until_start(output int c);
        c = 0;
        do begin adv(1); c++; end while (!bit_start_o && c < 5000);
    endtask

    task automatic until_sample(output int c);
        c = 0;
        do begin adv(1); c++; end while (!sample_o && c < 5000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        int c1, c2, dummy;
        adv(3);
        // R12: state while reset is held
        chk("R12 sample_o in reset", int'(sample_o), 0);
        chk("R12 bit_start_o in reset", int'(bit_start_o), 0);
        chk("R12 bit_o in reset", int'(bit_o), 1);
        rst = 1'b0;

        // table: free-running grid, line recessive, no edges
        for (int i = 0; i < 5; i++) begin
            brp_i = VEC[i].brp; tseg1_i = VEC[i].t1;
            tseg2_i = VEC[i].t2; sjw_i = VEC[i].sjw;
            until_start(dummy);
            until_sample(c1);
            chk("R3 strobes apart at sample", int'(bit_start_o), 0);
            until_start(c2);
            chk($sformatf("R2 vec%0d start-to-sample", i), c1, VEC[i].d1);
            chk($sformatf("R1 vec%0d bit period", i), c1 + c2, VEC[i].per);
        end

        // directed: 1 clock per quantum, 7+4+1 quanta, jump width 2
        rst = 1'b1;
        brp_i = 5'd0; tseg1_i = 4'd6; tseg2_i = 3'd3; sjw_i = 2'd1;
        rx_i = 1'b1; bus_idle_i = 1'b1; tx_dom_i = 1'b0; triple_i = 1'b0;
        adv(2);
        chk("R12 bit_o after reset", int'(bit_o), 1);
        rst = 1'b0;
        adv(20);
        rx_i = 1'b0;
        adv(1);                                   // E
        chk("R4 hard sync start", int'(bit_start_o), 1);
        bus_idle_i = 1'b0;
        adv(6);                                   // E+6
        chk("R4 no early sample", int'(sample_o), 0);
        adv(1);                                   // E+7
        chk("R4 sample after hard sync", int'(sample_o), 1);
        chk("R11 raw bit dominant", int'(bit_o), 0);
        rx_i = 1'b1;
        adv(5);                                   // E+12
        chk("R1 next bit start", int'(bit_start_o), 1);
        adv(1);                                   // E+13
        rx_i = 1'b0;                              // seen in TS1 quantum 1
        adv(6);                                   // E+19
        chk("R5 sample delayed", int'(sample_o), 0);
        adv(2);                                   // E+21
        chk("R5 sample stretched by 2", int'(sample_o), 1);
        rx_i = 1'b1;
        adv(1);                                   // E+22
        rx_i = 1'b0;                              // second edge same bit
        adv(2);                                   // E+24
        chk("R7 no second correction", int'(bit_start_o), 0);
        adv(2);                                   // F = E+26
        chk("R7 boundary kept", int'(bit_start_o), 1);
        rx_i = 1'b1;
        adv(7);                                   // F+7
        chk("R10 rising edge keeps sample", int'(sample_o), 1);
        chk("R11 raw bit recessive", int'(bit_o), 1);
        adv(1);                                   // F+8
        rx_i = 1'b0;                              // TS2 quantum 1, early by 3
        adv(1);                                   // F+9
        chk("R6 clipped: no start yet", int'(bit_start_o), 0);
        adv(1);                                   // G = F+10
        chk("R6 clipped shortening", int'(bit_start_o), 1);
        rx_i = 1'b1;
        adv(10);                                  // G+10
        chk("R6 no start before edge", int'(bit_start_o), 0);
        rx_i = 1'b0;                              // TS2 last quantum, early by 1
        adv(1);                                   // H = G+11
        chk("R6 full correction start", int'(bit_start_o), 1);
        rx_i = 1'b1;
        tx_dom_i = 1'b1;
        adv(1);                                   // H+1
        rx_i = 1'b0;                              // own dominant edge
        adv(6);                                   // H+7
        chk("R8 sample not moved", int'(sample_o), 1);
        tx_dom_i = 1'b0;
        rx_i = 1'b1;
        adv(4);                                   // H+11
        rx_i = 1'b0;                              // seen in sync quantum
        adv(1);                                   // H+12
        chk("R9 start on schedule", int'(bit_start_o), 1);
        adv(6);                                   // H+18
        chk("R9 no early sample", int'(sample_o), 0);
        adv(1);                                   // H+19
        chk("R9 sample unshifted", int'(sample_o), 1);
        triple_i = 1'b1;
        adv(5);                                   // J = H+24
        chk("R9 period unchanged", int'(bit_start_o), 1);
        adv(6);                                   // J+6
        rx_i = 1'b1;                              // 0,0,1 at sample
        adv(1);                                   // J+7
        chk("R11 vote sample", int'(sample_o), 1);
        chk("R11 majority low", int'(bit_o), 0);
        tx_dom_i = 1'b1;
        adv(5);                                   // K = J+12
        chk("R11 vote bit start", int'(bit_start_o), 1);
        adv(6);                                   // K+6
        rx_i = 1'b0;                              // 1,1,0 at sample
        adv(1);                                   // K+7
        chk("R11 vote sample 2", int'(sample_o), 1);
        chk("R11 majority high", int'(bit_o), 1);
        adv(3);
        finish_up();
    end
endmodule